// File: doc/BRIEF.md
# Multi-Format Serial Line Encoder

This block takes a serial bit stream, one bit per bit period, and drives it onto a single line in one of four line codes. The supported codes are plain level (NRZ), transition-on-one (NRZI), return-to-zero (RZ) and Manchester. Everything runs on one system clock. A one-cycle strobe, `half_tick`, pulses at exactly twice the bit rate, and the block counts alternate strobes as the first and second half of a bit period.

On every first-half strobe the block captures the input bit and the code select. Both are held for the whole period, so a bit is never sent in a mix of codes. The line output is a register that changes only on strobe cycles.

The parameter `MANCH_MOORE` picks how the Manchester path is built. With 0, the Manchester half-value is computed from the captured bit and the current half (Mealy form). With 1, a one-bit state register drives the Manchester output directly (Moore form), and the line lags the Mealy form by one half-bit.

Top module: `serial_line_encoder`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) drives `line_out` low and clears the NRZI level to 0. It also sets the half-bit phase so that the next `half_tick` is a first-half strobe, and clears the Moore Manchester state to 0.
- R2: With code 0 (NRZ), `line_out` equals the captured bit in both halves of the bit period.
- R3: With code 1 (NRZI), the first half drives the stored level XOR the captured bit and stores that result as the new level. The second half drives the stored level. The level is kept unchanged while other codes are in use.
- R4: With code 2 (RZ), a captured 1 gives high in the first half and low in the second half. A captured 0 gives low in both halves.
- R5: With code 3 (Manchester) and `MANCH_MOORE`=0, the first half drives the captured bit and the second half drives its inverse.
- R6: With `MANCH_MOORE`=1, a one-bit state register is loaded on every strobe, whatever the code. It takes the captured bit on a first half and the inverted captured bit on a second half. With code 3, each strobe drives the state held before that strobe (0 after reset). The line therefore lags R5 by one half-bit.
- R7: `line_out` is updated on the clock edge that samples `half_tick` high and holds its value on every other cycle.
- R8: `data_in` and `code_sel` are sampled only on first-half strobes. Changes to them during a bit period do not affect that period's second half.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| half_tick | input | 1 | One-cycle strobe at twice the bit rate |
| data_in | input | 1 | Serial input bit, sampled at first-half strobes |
| code_sel | input | 2 | Line code: 0 NRZ, 1 NRZI, 2 RZ, 3 Manchester |
| line_out | output | 1 | Registered encoded line |

## Verification
The hardest case to reach is a bit whose inputs change between its two halves. The second half must still follow the values captured at the first strobe. The stimulus changes both `code_sel` and `data_in` between the two strobes of a bit, to values whose encoding would give the opposite second-half level.

The stimulus also applies reset in the middle of a bit while the NRZI level is 1. This exposes any phase or level that survives reset. Two instances, one in Mealy form and one in Moore form, share the same stimulus so that the half-bit lag can be compared directly.

// File: rtl/sle_pkg.sv
package sle_pkg;

  typedef enum logic [1:0] {
    CODE_NRZ  = 2'd0,
    CODE_NRZI = 2'd1,
    CODE_RZ   = 2'd2,
    CODE_MAN  = 2'd3
  } line_code_e;

endpackage

// File: rtl/sle_phase.sv
module sle_phase (
  input  logic clk,
  input  logic rst,
  input  logic half_tick,
  output logic first_tick,
  output logic second_tick,
  output logic in_second
);

  logic second_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      second_q <= 1'b0;
    end else if (half_tick) begin
      second_q <= ~second_q;
    end
  end

  assign in_second   = second_q;
  assign first_tick  = half_tick & ~second_q;
  assign second_tick = half_tick & second_q;

  // R1 R7: phase alternates on every strobe
  phase_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    half_tick |=> (second_q != $past(second_q)));

  // R7: phase holds between strobes
  phase_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !half_tick |=> $stable(second_q));

endmodule

// File: rtl/sle_capture.sv
module sle_capture
  import sle_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       first_tick,
  input  logic       data_in,
  input  line_code_e code_in,
  output logic       bit_q,
  output line_code_e mode_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_q  <= 1'b0;
      mode_q <= CODE_NRZ;
    end else if (first_tick) begin
      bit_q  <= data_in;
      mode_q <= code_in;
    end
  end

  // R8: captured bit and code only move on first-half strobes
  capture_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !first_tick |=> ($stable(bit_q) && $stable(mode_q)));

endmodule

// File: rtl/sle_nrzi.sv
module sle_nrzi (
  input  logic clk,
  input  logic rst,
  input  logic first_tick,
  input  logic active,
  input  logic cur_bit,
  output logic half_val
);

  logic level_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      level_q <= 1'b0;
    end else if (first_tick && active && cur_bit) begin
      level_q <= ~level_q;
    end
  end

  assign half_val = first_tick ? (level_q ^ cur_bit) : level_q;

  // R3: level never moves outside a first-half strobe
  level_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !first_tick |=> $stable(level_q));

endmodule

// File: rtl/sle_man_mealy.sv
module sle_man_mealy (
  input  logic first_half,
  input  logic cur_bit,
  output logic half_val
);

  assign half_val = first_half ? cur_bit : ~cur_bit;

endmodule

// File: rtl/sle_man_moore.sv
module sle_man_moore (
  input  logic clk,
  input  logic rst,
  input  logic half_tick,
  input  logic first_half,
  input  logic cur_bit,
  output logic half_val
);

  logic state_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= 1'b0;
    end else if (half_tick) begin
      state_q <= first_half ? cur_bit : ~cur_bit;
    end
  end

  assign half_val = state_q;

  // R6: the state flips across a second-half strobe
  man_flip_chk: assert property (@(posedge clk) disable iff (rst)
    (half_tick && !first_half) |=> (state_q != $past(state_q)));

endmodule

// File: rtl/serial_line_encoder.sv
module serial_line_encoder
  import sle_pkg::*;
#(
  parameter bit MANCH_MOORE = 1'b0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       half_tick,
  input  logic       data_in,
  input  logic [1:0] code_sel,
  output logic       line_out
);

  logic       first_tick;
  logic       second_tick;
  logic       in_second;
  logic       bit_q;
  line_code_e mode_q;
  line_code_e cur_mode;
  logic       cur_bit;
  logic       nrzi_val;
  logic       man_val;
  logic       next_val;
  logic       line_q;

  sle_phase u_phase (
    .clk         (clk),
    .rst         (rst),
    .half_tick   (half_tick),
    .first_tick  (first_tick),
    .second_tick (second_tick),
    .in_second   (in_second)
  );

  sle_capture u_capture (
    .clk        (clk),
    .rst        (rst),
    .first_tick (first_tick),
    .data_in    (data_in),
    .code_in    (line_code_e'(code_sel)),
    .bit_q      (bit_q),
    .mode_q     (mode_q)
  );

  assign cur_mode = first_tick ? line_code_e'(code_sel) : mode_q;
  assign cur_bit  = first_tick ? data_in : bit_q;

  sle_nrzi u_nrzi (
    .clk        (clk),
    .rst        (rst),
    .first_tick (first_tick),
    .active     (cur_mode == CODE_NRZI),
    .cur_bit    (cur_bit),
    .half_val   (nrzi_val)
  );

  generate
    if (MANCH_MOORE) begin : g_moore
      sle_man_moore u_man (
        .clk        (clk),
        .rst        (rst),
        .half_tick  (half_tick),
        .first_half (~in_second),
        .cur_bit    (cur_bit),
        .half_val   (man_val)
      );
    end else begin : g_mealy
      sle_man_mealy u_man (
        .first_half (~in_second),
        .cur_bit    (cur_bit),
        .half_val   (man_val)
      );
    end
  endgenerate

  always_comb begin
    unique case (cur_mode)
      CODE_NRZ:  next_val = cur_bit;
      CODE_NRZI: next_val = nrzi_val;
      CODE_RZ:   next_val = first_tick & cur_bit;
      default:   next_val = man_val;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      line_q <= 1'b0;
    end else if (half_tick) begin
      line_q <= next_val;
    end
  end

  assign line_out = line_q;

  // R7
  line_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !half_tick |=> $stable(line_out));

  // R4
  rz_low_chk: assert property (@(posedge clk) disable iff (rst)
    (second_tick && mode_q == CODE_RZ) |=> !line_out);

  // R2
  nrz_flat_chk: assert property (@(posedge clk) disable iff (rst)
    (second_tick && mode_q == CODE_NRZ) |=> $stable(line_out));

  generate
    if (!MANCH_MOORE) begin : g_mealy_chk
      // R5
      man_mid_chk: assert property (@(posedge clk) disable iff (rst)
        (second_tick && mode_q == CODE_MAN) |=> (line_out != $past(line_out)));
    end
  endgenerate

endmodule

// File: tb/serial_line_encoder_tb.sv
module serial_line_encoder_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       half_tick = 1'b0;
  logic       data_in = 1'b0;
  logic [1:0] code_sel = 2'd0;
  logic       line_mealy;
  logic       line_moore;

  int checks = 0;
  int errors = 0;

  // model state derived from the requirements
  logic       ph  = 1'b0;
  logic [1:0] cm  = 2'd0;
  logic       cb  = 1'b0;
  logic       mst = 1'b0;

  always #2 clk = ~clk;

  serial_line_encoder #(.MANCH_MOORE(1'b0)) dut_i (
    .clk(clk), .rst(rst), .half_tick(half_tick),
    .data_in(data_in), .code_sel(code_sel), .line_out(line_mealy)
  );

  serial_line_encoder #(.MANCH_MOORE(1'b1)) dut_moore_i (
    .clk(clk), .rst(rst), .half_tick(half_tick),
    .data_in(data_in), .code_sel(code_sel), .line_out(line_moore)
  );

  // {code[1:0], bit, first-half expected, second-half expected} for Mealy form
  localparam logic [4:0] VEC [16] = '{
    {2'd0, 1'b1, 1'b1, 1'b1},   // R2
    {2'd0, 1'b0, 1'b0, 1'b0},   // R2
    {2'd1, 1'b1, 1'b1, 1'b1},   // R3
    {2'd1, 1'b0, 1'b1, 1'b1},   // R3
    {2'd1, 1'b1, 1'b0, 1'b0},   // R3
    {2'd1, 1'b1, 1'b1, 1'b1},   // R3
    {2'd2, 1'b1, 1'b1, 1'b0},   // R4
    {2'd2, 1'b0, 1'b0, 1'b0},   // R4
    {2'd3, 1'b0, 1'b0, 1'b1},   // R5
    {2'd3, 1'b1, 1'b1, 1'b0},   // R5
    {2'd3, 1'b1, 1'b1, 1'b0},   // R5
    {2'd1, 1'b0, 1'b1, 1'b1},   // R3 level kept across other codes
    {2'd2, 1'b1, 1'b1, 1'b0},   // R4
    {2'd3, 1'b0, 1'b0, 1'b1},   // R5
    {2'd0, 1'b1, 1'b1, 1'b1},   // R2
    {2'd1, 1'b1, 1'b0, 1'b0}    // R3
  };

  task automatic check(input string tag, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b", tag, got, exp);
    end
  endtask

  task automatic half_step(input logic exp_mealy, input string tag);
    logic mv;
    logic exp_moore;
    if (!ph) begin
      cm = code_sel;
      cb = data_in;
    end
    mv = ph ? ~cb : cb;
    exp_moore = (cm == 2'd3) ? mst : exp_mealy;  // R6
    mst = mv;
    ph = ~ph;
    half_tick = 1'b1;
    @(posedge clk);
    @(negedge clk);
    half_tick = 1'b0;
    check(tag, line_mealy, exp_mealy);
    check({tag, " R6 moore"}, line_moore, exp_moore);
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      check("R7 hold", line_mealy, exp_mealy);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    ph = 1'b0;
    mst = 1'b0;
    check("R1 reset mealy", line_mealy, 1'b0);
    check("R1 reset moore", line_moore, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();

    for (int k = 0; k < 16; k++) begin
      code_sel = VEC[k][4:3];
      data_in  = VEC[k][2];
      half_step(VEC[k][1], "R2-5 table first");
      half_step(VEC[k][0], "R2-5 table second");
    end

    // R8: inputs change between the two halves of a Manchester 0
    code_sel = 2'd3; data_in = 1'b0;
    half_step(1'b0, "R8 first");
    code_sel = 2'd2; data_in = 1'b1;
    half_step(1'b1, "R8 second");

    // R8: NRZ 1 with data dropping mid-bit
    code_sel = 2'd0; data_in = 1'b1;
    half_step(1'b1, "R8 nrz first");
    data_in = 1'b0;
    half_step(1'b1, "R8 nrz second");

    // R1: reset in mid-bit with NRZI level at 1
    code_sel = 2'd1; data_in = 1'b1;
    half_step(1'b1, "R3 before reset");
    do_reset();
    code_sel = 2'd1; data_in = 1'b0;
    half_step(1'b0, "R1 level cleared first");
    half_step(1'b0, "R1 level cleared second");
    code_sel = 2'd3; data_in = 1'b1;
    half_step(1'b1, "R1 phase aligned first");
    half_step(1'b0, "R1 phase aligned second");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule